// File: doc/BRIEF.md
# Byte Programmer with Conditional Word Erase

This block performs single-byte writes into a small nonvolatile storage model arranged as 32-bit words of four bytes each. A bus write supplies a byte address and a data byte. The block then looks at the word that holds that byte. When every byte of the word still holds the erased value, the byte is programmed at once. When any byte of the word holds data, the block first erases the whole word, then programs the new byte and puts back the three neighbouring bytes it saved when the write was accepted.

A mode input makes every write take the erase path, so that each write lasts the same number of cycles whatever the array holds. Erase and program phases are cycle counters whose lengths are parameters. While an operation runs, `busy` is high. When it ends, a done flag and a level interrupt rise and stay up until software reads the status. A write that arrives while the block is busy is dropped and raises a sticky error flag. A combinational byte read port lets the storage contents be observed.

Top module: `byte_prog_top`

## Requirements
- R1: A word is blank only when all four of its bytes equal 8'hFF. A byte written as 8'hFF leaves its word blank.
- R2: With `fix_time` low at acceptance and the target word blank, `busy` is high for exactly WRITE_CYC cycles and no erase occurs.
- R3: With the target word not blank, `busy` is high for exactly ERASE_CYC + WRITE_CYC cycles.
- R4: With `fix_time` high at acceptance, `busy` is high for ERASE_CYC + WRITE_CYC cycles even when the word is blank.
- R5: Once the erase phase ends and until the program phase ends, all four bytes of the target word read 8'hFF.
- R6: When the operation completes, the target byte holds the new data and the other three bytes of the word hold the values they had at acceptance.
- R7: After a fast write into a blank word, a write to another byte of the same word takes the erase path (the R3 duration).
- R8: `done` rises in the cycle `busy` falls, `irq` equals `done`, and `done` clears on a `stat_rd` pulse or when a new write is accepted.
- R9: A write that arrives while `busy` is high changes no storage, does not lengthen the running operation, and sets `err_busy`. `err_busy` stays set until `stat_rd`.
- R10: After reset, every byte reads 8'hFF and `busy`, `done`, `err_busy` and `irq` are low.
- R11: `fix_time` is sampled only in the acceptance cycle. Lowering it afterwards does not shorten the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write request strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte to program |
| fix_time | input | 1 | Force the erase phase on every write |
| stat_rd | input | 1 | Status read strobe. Clears `done` and `err_busy` |
| rd_addr | input | ADDR_W | Byte address for the read port |
| rd_data | output | 8 | Storage byte at `rd_addr` (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Sticky end-of-operation flag |
| err_busy | output | 1 | Sticky flag for a write rejected while busy |
| irq | output | 1 | Interrupt request, equal to `done` |

## Verification
A wrong blank decision or a wrong phase choice shows directly in the length of the `busy` pulse. That length is known the moment `busy` falls, which is at most ERASE_CYC + WRITE_CYC cycles after the write. A lost saved word or a wrong byte lane shows on `rd_data` as soon as the operation completes, through corrupted neighbours or a misplaced byte. A missed erase shows on `rd_data` during the program phase, one cycle after the erase ends. Wrong flag handling shows on `done`, `irq` or `err_busy` in the cycle after the edge that should set or clear them.

// File: rtl/byte_prog_pkg.sv
package byte_prog_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef logic [31:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    function automatic logic word_blank(input word_t w);
        return (w == {4{ERASED_BYTE}});
    endfunction

    function automatic word_t merge_byte(input word_t w, input logic [1:0] lane,
                                         input logic [7:0] b);
        word_t r;
        r = w;
        r[lane*8 +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/byte_prog_timer.sv
module byte_prog_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          at_zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/byte_prog_array.sv
module byte_prog_array
    import byte_prog_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-3:0] widx,
    output word_t             word_o,
    input  logic              erase_i,
    input  logic              prog_i,
    input  word_t             prog_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int BYTES = 2 ** ADDR_W;

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= ERASED_BYTE;
        end else if (erase_i) begin
            for (int b = 0; b < 4; b++) mem[{widx, 2'(b)}] <= ERASED_BYTE;
        end else if (prog_i) begin
            for (int b = 0; b < 4; b++) mem[{widx, 2'(b)}] <= prog_word[b*8 +: 8];
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++) word_o[b*8 +: 8] = mem[{widx, 2'(b)}];
    end

    assign rd_data = mem[rd_addr];

    assert_erase_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (erase_i && $stable(widx)) |=> word_blank(word_o));
endmodule

// File: rtl/byte_prog_ctrl.sv
module byte_prog_ctrl
    import byte_prog_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ERASE_CYC = 8,
    parameter int WRITE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              fix_time,
    input  logic              stat_rd,
    input  word_t             arr_word,
    output logic [ADDR_W-3:0] arr_widx,
    output logic              arr_erase,
    output logic              arr_prog,
    output word_t             arr_prog_word,
    output logic              busy,
    output logic              done,
    output logic              err_busy
);
    localparam int TOTAL = ERASE_CYC + WRITE_CYC;
    localparam int CW    = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [ADDR_W-3:0] widx;
        logic [1:0]        lane;
        logic [7:0]        data;
        word_t             saved;
    } job_t;

    phase_e        phase;
    job_t          job;
    logic          accept, at_zero, t_load;
    logic [CW-1:0] t_val;
    logic          need_erase;

    assign busy       = (phase != PH_IDLE);
    assign accept     = (phase == PH_IDLE) && wr_en;
    assign arr_widx   = busy ? job.widx : wr_addr[ADDR_W-1:2];
    assign need_erase = fix_time || !word_blank(arr_word);

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (accept) begin
            t_load = 1'b1;
            t_val  = need_erase ? CW'(ERASE_CYC - 1) : CW'(WRITE_CYC - 1);
        end else if (phase == PH_ERASE && at_zero) begin
            t_load = 1'b1;
            t_val  = CW'(WRITE_CYC - 1);
        end
    end

    byte_prog_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .at_zero(at_zero)
    );

    assign arr_erase     = (phase == PH_ERASE) && at_zero;
    assign arr_prog      = (phase == PH_WRITE) && at_zero;
    assign arr_prog_word = merge_byte(job.saved, job.lane, job.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            job      <= '0;
            done     <= 1'b0;
            err_busy <= 1'b0;
        end else begin
            if (stat_rd) begin
                done     <= 1'b0;
                err_busy <= 1'b0;
            end
            if (busy && wr_en) err_busy <= 1'b1;
            unique case (phase)
                PH_IDLE: if (accept) begin
                    job.widx  <= wr_addr[ADDR_W-1:2];
                    job.lane  <= wr_addr[1:0];
                    job.data  <= wr_data;
                    job.saved <= arr_word;
                    done      <= 1'b0;
                    phase     <= need_erase ? PH_ERASE : PH_WRITE;
                end
                PH_ERASE: if (at_zero) phase <= PH_WRITE;
                PH_WRITE: if (at_zero) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // run-length watch for the busy window
    logic [CW:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        run_len <= (CW+1)'(TOTAL));
    assert_fast_path_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !fix_time && word_blank(arr_word)) |=> (phase == PH_WRITE));
    assert_fix_erase_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && fix_time) |=> (phase == PH_ERASE));
    assert_reject_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> err_busy);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_done_on_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

// File: rtl/byte_prog_top.sv
module byte_prog_top
    import byte_prog_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ERASE_CYC = 8,
    parameter int WRITE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              fix_time,
    input  logic              stat_rd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              err_busy,
    output logic              irq
);
    word_t             arr_word, prog_word;
    logic [ADDR_W-3:0] widx;
    logic              erase_s, prog_s;

    byte_prog_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fix_time(fix_time), .stat_rd(stat_rd), .arr_word(arr_word),
        .arr_widx(widx), .arr_erase(erase_s), .arr_prog(prog_s),
        .arr_prog_word(prog_word), .busy(busy), .done(done), .err_busy(err_busy)
    );

    byte_prog_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .widx(widx), .word_o(arr_word), .erase_i(erase_s),
        .prog_i(prog_s), .prog_word(prog_word), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign irq = done;
endmodule

// File: tb/byte_prog_top_tb.sv
module byte_prog_top_tb;
    localparam int AW = 6, EC = 8, WC = 4;

    logic clk = 0, rst = 1;
    logic wr_en = 0, fix_time = 0, stat_rd = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic busy, done, err_busy, irq;

    int checks = 0, errors = 0;

    typedef struct { int cyc; string req; } exp_t;
    exp_t q[$];

    byte_prog_top #(.ADDR_W(AW), .ERASE_CYC(EC), .WRITE_CYC(WC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fix_time(fix_time), .stat_rd(stat_rd), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .err_busy(err_busy), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: measures each busy pulse and compares against the queue
    initial begin
        int cnt = 0;
        logic prev = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (busy) cnt++;
            if (prev && !busy) begin
                if (q.size() == 0) chk("unexpected op", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(e.req, cnt, e.cyc);
                    chk("R8 done at end", done, 1);
                    chk("R8 irq follows done", irq, 1);
                end
                cnt = 0;
            end
            prev = busy;
        end
    end

    task automatic drive(input logic [AW-1:0] a, input logic [7:0] d, input logic fx,
                         input int cyc, input string req);
        wr_addr = a; wr_data = d; wr_en = 1; fix_time = fx;
        q.push_back('{cyc, req});
        @(negedge clk);
        wr_en = 0; fix_time = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        rd_addr = a; #1;
        chk(req, rd_data, exp);
    endtask

    task automatic status_read();
        stat_rd = 1; @(negedge clk); stat_rd = 0; #1;
    endtask

    initial begin
        #200_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; #1;
        chk("R10 busy", busy, 0); chk("R10 done", done, 0);
        chk("R10 err", err_busy, 0); chk("R10 irq", irq, 0);
        rd(0, 8'hFF, "R10 erased"); rd(63, 8'hFF, "R10 erased");

        // fast write into blank word
        drive(5, 8'h3C, 0, WC, "R2 blank fast");
        wait_idle();
        rd(5, 8'h3C, "R6 target"); rd(4, 8'hFF, "R6 neighbour"); rd(7, 8'hFF, "R6 neighbour");
        status_read();
        chk("R8 cleared by stat_rd", done, 0); chk("R8 irq cleared", irq, 0);

        // second byte of same word must erase
        drive(6, 8'h5A, 0, EC + WC, "R7 same word slow");
        repeat (EC) @(negedge clk);
        rd(5, 8'hFF, "R5 erased mid"); rd(6, 8'hFF, "R5 erased mid");
        wait_idle();
        rd(4, 8'hFF, "R6 restore"); rd(5, 8'h3C, "R6 restore");
        rd(6, 8'h5A, "R6 target"); rd(7, 8'hFF, "R6 restore");

        // new accept clears done
        drive(7, 8'h01, 0, EC + WC, "R3 nonblank");
        #1 chk("R8 cleared on accept", done, 0);
        wait_idle();
        rd(5, 8'h3C, "R6 keep"); rd(6, 8'h5A, "R6 keep"); rd(7, 8'h01, "R6 target");
        status_read();

        // fix mode on blank word, fix dropped after acceptance
        drive(12, 8'hA5, 1, EC + WC, "R4 R11 fixed timing");
        wait_idle();
        rd(12, 8'hA5, "R4 data");

        // FF into blank word keeps it blank
        drive(20, 8'hFF, 0, WC, "R1 ff write fast");
        wait_idle();
        drive(21, 8'h77, 0, WC, "R1 still blank");
        wait_idle();
        rd(21, 8'h77, "R1 data");
        status_read();

        // write rejected while busy
        drive(9, 8'h00, 0, WC, "R9 op not lengthened");
        wr_addr = 10; wr_data = 8'h11; wr_en = 1;
        @(negedge clk); wr_en = 0; #1;
        chk("R9 err set", err_busy, 1);
        wait_idle();
        rd(9, 8'h00, "R9 first op"); rd(10, 8'hFF, "R9 ignored");
        chk("R9 err sticky", err_busy, 1);
        status_read();
        chk("R9 err cleared", err_busy, 0);

        repeat (3) @(negedge clk);
        chk("queue drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule